// File: doc/BRIEF.md
# Masked Drum Sequencer

A twelve-step pattern sequencer that stands in for a rotating peg drum. Each step holds a 16-bit output pattern in a small register table that is loaded through a synchronous write port. A rising edge on the advance input moves the step pointer forward by exactly one step, but only while the enable input is high. On each such advance, the pattern of the step being entered is copied to the output word.

A mask word selects which output bits the sequencer controls. Bits whose mask bit is 0 keep the value they already had. The output therefore becomes `(previous & ~mask) | (pattern & mask)`. After the last step the pointer returns to the first step, and a one-cycle done pulse marks that wrap.

Top module: `drum_seq`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `step_o` is 1, `out_o` is 0 and `done_o` is 0.
- R2: A 0-to-1 transition of `adv_i` seen at a rising clock edge while `en_i` is high moves `step_o` forward by exactly one at that edge. Holding `adv_i` high causes no further steps.
- R3: While `en_i` is low, edges on `adv_i` are ignored and `step_o` and `out_o` stay unchanged.
- R4: An advance from step 12 sets `step_o` to 1 and raises `done_o` for exactly that one cycle. `done_o` is 0 at every other time.
- R5: On an advance, `out_o` becomes `(out_o & ~mask_i) | (P & mask_i)`, where P is the pattern of the step being entered, read before any write on the same edge takes effect. Without an advance, `out_o` holds its value.
- R6: With `mask_i` all zero, an advance moves the step but leaves `out_o` unchanged.
- R7: A write with `wr_en_i` high and `wr_addr_i` in the range 0..11 stores `wr_data_i` as the pattern of step `wr_addr_i`+1. That pattern is used the next time this step is entered.
- R8: Writes to `wr_addr_i` 12..15 change no stored pattern.
- R9: Reset does not alter the stored patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Stepping enable |
| adv_i | input | 1 | Advance request; acts on its rising edge |
| wr_en_i | input | 1 | Table write strobe |
| wr_addr_i | input | 4 | Table address; address a holds the pattern of step a+1 |
| wr_data_i | input | 16 | Pattern to write |
| mask_i | input | 16 | 1 = bit driven by the sequence |
| out_o | output | 16 | Masked output word |
| step_o | output | 4 | Current step, 1 to 12 |
| done_o | output | 1 | One-cycle pulse on wrap from 12 to 1 |

## Verification
A corrupted step pointer appears on `step_o` in the cycle after the advance that produced it. From then on, every following advance loads `out_o` with the wrong row, so a single error keeps showing until the next reset. A table entry that aliases or loses a write stays hidden until its step is entered with a non-zero mask. For that reason the directed runs walk the whole drum with a full mask after the out-of-range writes. A wrong wrap shows as a missing or shifted `done_o` pulse within twelve advances.

// File: rtl/drum_seq_pkg.sv
package drum_seq_pkg;
  localparam int unsigned DEF_STEPS  = 12;
  localparam int unsigned DEF_WIDTH  = 16;
  localparam int unsigned DEF_ADDR_W = 4;

  function automatic int unsigned idx_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/seq_table.sv
module seq_table #(
  parameter int unsigned STEPS  = 12,
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  input  logic [IDX_W-1:0]  raddr_i,
  output logic [WIDTH-1:0]  rdata_o
);
  logic [WIDTH-1:0] mem_q [STEPS];

  // no reset: contents survive rst_ni (R9); addresses >= STEPS never match (R8)
  always_ff @(posedge clk_i) begin
    for (int i = 0; i < STEPS; i++) begin
      if (we_i && waddr_i == ADDR_W'(i)) mem_q[i] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < STEPS; i++) begin
      if (raddr_i == IDX_W'(i)) rdata_o = mem_q[i];
    end
  end

  p_write_lands_r7: assert property (@(posedge clk_i)
    (we_i && waddr_i < ADDR_W'(STEPS)) |=> mem_q[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/seq_step_ctr.sv
module seq_step_ctr #(
  parameter int unsigned STEPS = 12,
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             adv_i,
  output logic             step_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [IDX_W-1:0] nxt_idx_o,
  output logic             done_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(STEPS - 1);

  logic adv_q, rise;
  logic [IDX_W-1:0] idx_q;
  logic done_q;

  assign rise      = adv_i & ~adv_q;
  assign step_o    = rise & en_i;
  assign nxt_idx_o = (idx_q == LAST) ? '0 : idx_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      adv_q  <= 1'b0;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      adv_q  <= adv_i;
      done_q <= step_o && (idx_q == LAST);
      if (step_o) idx_q <= nxt_idx_o;
    end
  end

  assign idx_o  = idx_q;
  assign done_o = done_q;

  p_idx_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= LAST);
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && adv_i && !adv_q) |=> $stable(idx_q));
  p_done_at_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> idx_q == '0);
  p_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && idx_q == LAST) |=> (done_q && idx_q == '0));
  p_done_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
endmodule

// File: rtl/seq_mask_out.sv
module seq_mask_out #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  logic [WIDTH-1:0] pat_i,
  input  logic [WIDTH-1:0] mask_i,
  output logic [WIDTH-1:0] out_o
);
  logic [WIDTH-1:0] out_q;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 out_q[b] <= 1'b0;
      else if (upd_i && mask_i[b]) out_q[b] <= pat_i[b];
    end
  end

  assign out_o = out_q;

  p_idle_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(out_q));
  p_masked_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> ((out_q ^ $past(out_q)) & ~$past(mask_i)) == '0);
endmodule

// File: rtl/drum_seq.sv
module drum_seq
  import drum_seq_pkg::*;
#(
  parameter int unsigned STEPS  = DEF_STEPS,
  parameter int unsigned WIDTH  = DEF_WIDTH,
  parameter int unsigned ADDR_W = DEF_ADDR_W
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           en_i,
  input  logic                           adv_i,
  input  logic                           wr_en_i,
  input  logic [ADDR_W-1:0]              wr_addr_i,
  input  logic [WIDTH-1:0]               wr_data_i,
  input  logic [WIDTH-1:0]               mask_i,
  output logic [WIDTH-1:0]               out_o,
  output logic [$clog2(STEPS+1)-1:0]     step_o,
  output logic                           done_o
);
  localparam int unsigned IDX_W  = idx_bits(STEPS);
  localparam int unsigned STEP_W = $clog2(STEPS + 1);

  logic             advance;
  logic [IDX_W-1:0] idx, nxt_idx;
  logic [WIDTH-1:0] pattern;

  seq_step_ctr #(.STEPS(STEPS), .IDX_W(IDX_W)) u_ctr (
    .clk_i, .rst_ni, .en_i, .adv_i,
    .step_o(advance), .idx_o(idx), .nxt_idx_o(nxt_idx), .done_o
  );

  seq_table #(.STEPS(STEPS), .WIDTH(WIDTH), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_tbl (
    .clk_i, .we_i(wr_en_i), .waddr_i(wr_addr_i), .wdata_i(wr_data_i),
    .raddr_i(nxt_idx), .rdata_o(pattern)
  );

  seq_mask_out #(.WIDTH(WIDTH)) u_out (
    .clk_i, .rst_ni, .upd_i(advance), .pat_i(pattern), .mask_i, .out_o
  );

  assign step_o = STEP_W'(idx) + 1'b1;

  p_step_bounds_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o >= 1 && step_o <= STEP_W'(STEPS));
endmodule

// File: tb/tb_drum_seq.sv
module tb_drum_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, adv = 1'b0, we = 1'b0;
  logic [3:0]  wa = '0;
  logic [15:0] wd = '0, mask = '0;
  logic [15:0] out;
  logic [3:0]  step;
  logic        done;

  int checks = 0, errors = 0;
  logic [15:0] tbl [12];
  logic [15:0] e_out;
  int          e_step;
  logic        e_done, prev_adv;
  bit          finished = 0;

  always #10 clk = ~clk;

  drum_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .adv_i(adv), .wr_en_i(we),
    .wr_addr_i(wa), .wr_data_i(wd), .mask_i(mask),
    .out_o(out), .step_o(step), .done_o(done)
  );

  function automatic logic [15:0] apply_mask(logic [15:0] o, logic [15:0] p, logic [15:0] m);
    return (o & ~m) | (p & m);
  endfunction

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "step", 16'(step), 16'(e_step));
    chk(tag, "out", out, e_out);
    chk(tag, "done", 16'(done), 16'(e_done));
  endtask

  // drive at negedge, model the edge, compare at next negedge
  task automatic tick(string tag, logic a, logic e, logic w, logic [3:0] ad,
                      logic [15:0] d, logic [15:0] m);
    int nxt;
    adv = a; en = e; we = w; wa = ad; wd = d; mask = m;
    @(posedge clk);
    e_done = 1'b0;
    if (e && a && !prev_adv) begin
      nxt = (e_step == 12) ? 1 : e_step + 1;
      e_done = (e_step == 12);
      e_out = apply_mask(e_out, tbl[nxt-1], m);
      e_step = nxt;
    end
    prev_adv = a;
    if (w && ad < 12) tbl[ad] = d;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; adv = 0; en = 0; we = 0;
    e_step = 1; e_out = '0; e_done = 0; prev_adv = 0;
    @(negedge clk);
    compare("R1");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");
  endtask

  // one full advance: rise then fall
  task automatic pulse(string tag, logic [15:0] m);
    tick(tag, 1'b1, 1'b1, 1'b0, 4'd0, 16'h0, m);
    tick(tag, 1'b0, 1'b1, 1'b0, 4'd0, 16'h0, m);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();

    // R7: load every row
    for (int i = 0; i < 12; i++)
      tick("R7", 0, 1, 1, 4'(i), 16'h0101 * 16'(i + 1) ^ 16'hA500, 16'hFFFF);
    // R8: out-of-range writes
    for (int i = 12; i < 16; i++)
      tick("R8", 0, 1, 1, 4'(i), 16'hDEAD, 16'hFFFF);
    // walk whole drum with full mask; row 1 re-entered after wrap exposes aliasing
    for (int i = 0; i < 12; i++) pulse("R8", 16'hFFFF);
    chk("R4", "wrap step", 16'(step), 16'd1);
    chk("R8", "row1 intact", out, tbl[0]);
    pulse("R5", 16'hFFFF);

    // R2: hold high -> one step only
    tick("R2", 1, 1, 0, 0, 0, 16'hFFFF);
    for (int i = 0; i < 5; i++) tick("R2", 1, 1, 0, 0, 0, 16'hFFFF);
    tick("R2", 0, 1, 0, 0, 0, 16'hFFFF);

    // R3: edges with enable low ignored
    for (int i = 0; i < 4; i++) begin
      tick("R3", 1, 0, 0, 0, 0, 16'hFFFF);
      tick("R3", 0, 0, 0, 0, 0, 16'hFFFF);
    end

    // R6: zero mask keeps output
    pulse("R6", 16'h0000);
    pulse("R6", 16'h0000);

    // R5: partial masks
    pulse("R5", 16'h00FF);
    pulse("R5", 16'hF0F0);

    // R7: rewrite next row, then enter it
    tick("R7", 0, 1, 1, 4'(e_step % 12), 16'h5A3C, 16'hFFFF);
    pulse("R7", 16'hFFFF);
    chk("R7", "new row", out, 16'h5A3C);

    // R9: reset keeps table
    do_reset();
    pulse("R9", 16'hFFFF);
    chk("R9", "row2 after reset", out, tbl[1]);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic a, e, w;
      logic [3:0] ad;
      logic [15:0] d, m;
      a = 1'($urandom);
      e = ($urandom % 8) != 0;
      w = ($urandom % 4) == 0;
      ad = 4'($urandom);
      d = 16'($urandom);
      case ($urandom % 4)
        0: m = 16'hFFFF;
        1: m = 16'h0000;
        default: m = 16'($urandom);
      endcase
      tick("R5", a, e, w, ad, d, m);
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule